// File: doc/BRIEF.md
# DSP Microcode Sequencer with Debug Control

This block steps a DSP through a fixed microprogram held in a 512-entry store of 64-bit instruction words. Software fills the store through a simple load port. Each stored word has two halves. The upper half carries a 4-bit opcode, a 10-bit result address and a 10-bit operand A. The lower half carries two 10-bit operands, X and Y. When the block issues an instruction, it presents the decoded fields together with the instruction's address to an external datapath, one instruction per clock.

In free-running mode a sample-rate tick starts one sweep of the whole program. The sweep covers addresses 0 to 511 in order, after which the block waits for the next tick. A debug word can instead switch the block into single-step mode. In that mode it halts, and each write that carries the step command issues exactly one instruction. The datapath reports two things back for each issued instruction: a 5-bit condition code and a saturation indication. The block keeps the last condition code and the address of the first instruction that saturated. It also owns the delay-memory base counter, which counts down once per tick.

The FSM has four states. S_IDLE waits for a tick. S_RUN sweeps the program. S_HALT is single-step mode, waiting for a step command. S_STEP issues one stepped instruction. The transitions are:
- t_start (S_IDLE to S_RUN on a tick).
- t_done (S_RUN to S_IDLE after address 511).
- t_halt (S_IDLE, S_RUN or S_HALT to S_HALT on a write with the mode bit set and the step bit clear).
- t_step (the same source states to S_STEP on a write with both bits set).
- t_back (S_STEP to S_HALT, always).
- t_resume (S_HALT to S_IDLE on a write with the mode bit clear).

Top module: `dsp_useq`

## Requirements
- R1: A load-port write stores `ld_data` at `ld_addr`. When that address is issued, the outputs carry the following fields:

  | Output | Source bits of `ld_data` |
  |---|---|
  | `op_code` | [55:52] |
  | `op_res` | [51:42] |
  | `op_a` | [41:32] |
  | `op_x` | [19:10] |
  | `op_y` | [9:0] |

  This means that in the upper word, bits 23:20 are the opcode, bits 19:10 are the result address and bits 9:0 are A. In the lower word, bits 19:10 are X and bits 9:0 are Y.
- R2: A tick sampled in S_IDLE starts a sweep. From the next clock on, `issue_vld` is high for 512 consecutive cycles, with `issue_pc` stepping 0, 1, …, 511.
- R3: A tick arriving during a sweep neither restarts nor lengthens the sweep. Exactly 512 instructions are issued per sweep.
- R4: After address 511 has been issued, the block returns to S_IDLE with the program counter at 0, and `issue_vld` falls on the following cycle.
- R5: A debug write with bit 15 set and bit 14 clear enters S_HALT and loads the program counter from `dbg_wdata[8:0]`. This also aborts any sweep in progress. While halted, `dbg_rdata[15]` reads 1 and ticks issue nothing.
- R6: A debug write with bits 15 and 14 both set loads the program counter from `dbg_wdata[8:0]`. The block then issues exactly that one instruction in the next cycle and returns to S_HALT, with the counter advanced by one. The counter wraps from 511 to 0. The mode, step and address fields of any write accepted during S_STEP are ignored.
- R7: A debug write with bit 15 clear, made while halted, returns the block to S_IDLE with the program counter at 0. The read view then shows `dbg_rdata[15]`=0 and `dbg_rdata[8:0]`=0.
- R8: `cc_in` is captured on every cycle in which `issue_vld` is high. The read view `dbg_rdata` has the following layout, with all other bits reading 0:

  | Bits | Content |
  |---|---|
  | [8:0] | program counter |
  | [13:9] | condition code |
  | [15] | step mode |
  | [24:16] | saturation address |
  | [25] | sticky saturation flag |

- R9: The first cycle in which `sat_in` and `issue_vld` are both high sets the flag and records `issue_pc` as the saturation address. Later saturations leave both unchanged while the flag is set.
- R10: A debug write with bit 25 set clears the flag. If a saturation occurs in the same cycle, the saturation wins: the flag stays set and the new address is recorded.
- R11: The 20-bit base counter `dbac` decrements by one on every tick in every state, wrapping from 0 to 0xFFFFF.
- R12: A debug write with bit 31 set zeroes `dbac`, taking precedence over a tick in the same cycle.
- R13: After reset the block is in S_IDLE with `issue_vld`=0, `dbg_rdata`=0 and `dbac`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Instruction load strobe |
| ld_addr | input | 9 | Instruction store address for a load |
| ld_data | input | 64 | Instruction word (upper half = opcode/result/A) |
| tick | input | 1 | Sample-rate tick |
| dbg_wr | input | 1 | Debug word write strobe |
| dbg_wdata | input | 32 | Debug write data |
| dbg_rdata | output | 32 | Debug read view |
| sat_in | input | 1 | Datapath reports saturation of the issued instruction |
| cc_in | input | 5 | Datapath condition code of the issued instruction |
| issue_vld | output | 1 | An instruction is being issued |
| issue_pc | output | 9 | Address of the issued instruction |
| op_code | output | 4 | Issued opcode |
| op_res | output | 10 | Issued result address |
| op_a | output | 10 | Issued operand A |
| op_x | output | 10 | Issued operand X |
| op_y | output | 10 | Issued operand Y |
| dbac | output | 20 | Delay-memory base address counter |

## Verification
The assertions check the following on every cycle:
- Each running cycle issues the counter's current address.
- A tick met mid-sweep only advances the counter.
- The last address leads back to idle.
- Halt issues nothing, and a step issues exactly one instruction before halting again.
- A set saturation flag holds its address until cleared.
- The base counter either decrements on a tick or zeroes on command.

Only the bench scenarios can show the remaining behaviours:
- Decoded field positions against loaded words.
- The total of 512 instructions per sweep despite a second tick.
- Address loading and wrap in step mode.
- The first-saturation address across sweeps, and clearing it.
- The precedence of zeroing over a simultaneous tick.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int OPC_W   = 4;
    localparam int FLD_W   = 10;
    localparam int CC_W    = 5;
    localparam int INSTR_W = 64;

    // debug word bit positions (read and write)
    localparam int DBG_ZERO_BIT = 31;
    localparam int DBG_SAT_BIT  = 25;
    localparam int DBG_SATA_LSB = 16;
    localparam int DBG_MODE_BIT = 15;
    localparam int DBG_STEP_BIT = 14;
    localparam int DBG_CC_LSB   = 9;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_HALT = 2'd2,
        S_STEP = 2'd3
    } useq_state_e;

    typedef struct packed {
        logic [OPC_W-1:0] opc;
        logic [FLD_W-1:0] res;
        logic [FLD_W-1:0] a;
        logic [FLD_W-1:0] x;
        logic [FLD_W-1:0] y;
    } useq_fields_t;

    function automatic useq_fields_t useq_decode(input logic [INSTR_W-1:0] w);
        useq_fields_t f;
        logic [31:0] hi;
        logic [31:0] lo;
        hi    = w[63:32];
        lo    = w[31:0];
        f.opc = hi[23:20];
        f.res = hi[19:10];
        f.a   = hi[9:0];
        f.x   = lo[19:10];
        f.y   = lo[9:0];
        return f;
    endfunction

endpackage

// File: rtl/useq_store.sv
module useq_store
    import useq_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_en,
    input  logic [ADDR_W-1:0]  ld_addr,
    input  logic [INSTR_W-1:0] ld_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    input  logic               cap_en,
    output logic [ADDR_W-1:0]  issue_pc,
    output useq_fields_t       issue_f
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [INSTR_W-1:0] mem [DEPTH];
    useq_fields_t       rd_f;

    always_ff @(posedge clk) begin
        if (ld_en) begin
            mem[ld_addr] <= ld_data;
        end
    end

    always_comb begin
        rd_f = useq_decode(mem[rd_addr]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issue_pc <= '0;
            issue_f  <= '0;
        end else if (cap_en) begin
            issue_pc <= rd_addr;
            issue_f  <= rd_f;
        end
    end

endmodule

// File: rtl/useq_fsm.sv
module useq_fsm
    import useq_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              dbg_wr,
    input  logic [31:0]       dbg_wdata,
    output useq_state_e       state_q,
    output logic [ADDR_W-1:0] pc_q,
    output logic              cap_en,
    output logic              issue_vld
);

    localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

    useq_state_e       state_d;
    logic [ADDR_W-1:0] pc_d;
    logic              mode_wr;
    logic              step_req;
    logic [ADDR_W-1:0] wr_pc;

    assign mode_wr  = dbg_wr && dbg_wdata[DBG_MODE_BIT];
    assign step_req = dbg_wdata[DBG_STEP_BIT];
    assign wr_pc    = dbg_wdata[ADDR_W-1:0];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            pc_q    <= '0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
        end
    end

    // next state and program counter
    always_comb begin
        state_d = state_q;
        pc_d    = pc_q;
        unique case (state_q)
            S_IDLE: begin
                if (mode_wr) begin
                    state_d = step_req ? S_STEP : S_HALT;
                    pc_d    = wr_pc;
                end else if (tick) begin
                    state_d = S_RUN;
                    pc_d    = '0;
                end
            end
            S_RUN: begin
                if (mode_wr) begin
                    state_d = step_req ? S_STEP : S_HALT;
                    pc_d    = wr_pc;
                end else if (pc_q == LAST) begin
                    state_d = S_IDLE;
                    pc_d    = '0;
                end else begin
                    pc_d = pc_q + 1'b1;
                end
            end
            S_HALT: begin
                if (mode_wr) begin
                    state_d = step_req ? S_STEP : S_HALT;
                    pc_d    = wr_pc;
                end else if (dbg_wr) begin
                    state_d = S_IDLE;
                    pc_d    = '0;
                end
            end
            S_STEP: begin
                state_d = S_HALT;
                pc_d    = pc_q + 1'b1;
            end
            default: begin
                state_d = S_IDLE;
                pc_d    = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        cap_en = (state_q == S_RUN) || (state_q == S_STEP);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issue_vld <= 1'b0;
        end else begin
            issue_vld <= cap_en;
        end
    end

endmodule

// File: rtl/useq_debug.sv
module useq_debug
    import useq_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int DBAC_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              dbg_wr,
    input  logic [31:0]       dbg_wdata,
    input  logic              issue_vld,
    input  logic [ADDR_W-1:0] issue_pc,
    input  logic              sat_in,
    input  logic [CC_W-1:0]   cc_in,
    input  useq_state_e       state_q,
    input  logic [ADDR_W-1:0] pc_q,
    output logic [31:0]       dbg_rdata,
    output logic [DBAC_W-1:0] dbac
);

    logic              sat_q;
    logic [ADDR_W-1:0] sata_q;
    logic [CC_W-1:0]   cc_q;
    logic              sat_clr;
    logic              sat_set;
    logic              step_mode;

    assign sat_clr   = dbg_wr && dbg_wdata[DBG_SAT_BIT];
    assign sat_set   = issue_vld && sat_in && (!sat_q || sat_clr);
    assign step_mode = (state_q == S_HALT) || (state_q == S_STEP);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sat_q  <= 1'b0;
            sata_q <= '0;
        end else if (sat_set) begin
            sat_q  <= 1'b1;
            sata_q <= issue_pc;
        end else if (sat_clr) begin
            sat_q  <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cc_q <= '0;
        end else if (issue_vld) begin
            cc_q <= cc_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbac <= '0;
        end else if (dbg_wr && dbg_wdata[DBG_ZERO_BIT]) begin
            dbac <= '0;
        end else if (tick) begin
            dbac <= dbac - 1'b1;
        end
    end

    always_comb begin
        dbg_rdata                                      = '0;
        dbg_rdata[ADDR_W-1:0]                          = pc_q;
        dbg_rdata[DBG_CC_LSB +: CC_W]                  = cc_q;
        dbg_rdata[DBG_MODE_BIT]                        = step_mode;
        dbg_rdata[DBG_SATA_LSB +: ADDR_W]              = sata_q;
        dbg_rdata[DBG_SAT_BIT]                         = sat_q;
    end

endmodule

// File: rtl/dsp_useq.sv
module dsp_useq
    import useq_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int DBAC_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [63:0]       ld_data,
    input  logic              tick,
    input  logic              dbg_wr,
    input  logic [31:0]       dbg_wdata,
    output logic [31:0]       dbg_rdata,
    input  logic              sat_in,
    input  logic [4:0]        cc_in,
    output logic              issue_vld,
    output logic [ADDR_W-1:0] issue_pc,
    output logic [3:0]        op_code,
    output logic [9:0]        op_res,
    output logic [9:0]        op_a,
    output logic [9:0]        op_x,
    output logic [9:0]        op_y,
    output logic [DBAC_W-1:0] dbac
);

    useq_state_e       fsm_state;
    logic [ADDR_W-1:0] cur_pc;
    logic              cap_en;
    useq_fields_t      issue_f;

    useq_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .dbg_wr    (dbg_wr),
        .dbg_wdata (dbg_wdata),
        .state_q   (fsm_state),
        .pc_q      (cur_pc),
        .cap_en    (cap_en),
        .issue_vld (issue_vld)
    );

    useq_store #(.ADDR_W(ADDR_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_en    (ld_en),
        .ld_addr  (ld_addr),
        .ld_data  (ld_data),
        .rd_addr  (cur_pc),
        .cap_en   (cap_en),
        .issue_pc (issue_pc),
        .issue_f  (issue_f)
    );

    useq_debug #(.ADDR_W(ADDR_W), .DBAC_W(DBAC_W)) u_debug (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .dbg_wr    (dbg_wr),
        .dbg_wdata (dbg_wdata),
        .issue_vld (issue_vld),
        .issue_pc  (issue_pc),
        .sat_in    (sat_in),
        .cc_in     (cc_in),
        .state_q   (fsm_state),
        .pc_q      (cur_pc),
        .dbg_rdata (dbg_rdata),
        .dbac      (dbac)
    );

    assign op_code = issue_f.opc;
    assign op_res  = issue_f.res;
    assign op_a    = issue_f.a;
    assign op_x    = issue_f.x;
    assign op_y    = issue_f.y;

endmodule

// File: rtl/dsp_useq_chk.sv
module dsp_useq_chk
    import useq_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int DBAC_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              dbg_wr,
    input logic [31:0]       dbg_wdata,
    input logic              issue_vld,
    input logic [ADDR_W-1:0] issue_pc,
    input logic [31:0]       dbg_rdata,
    input logic [DBAC_W-1:0] dbac,
    input useq_state_e       fsm_state,
    input logic [ADDR_W-1:0] cur_pc
);

    localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

    logic mode_wr;
    assign mode_wr = dbg_wr && dbg_wdata[DBG_MODE_BIT];

    a_r2_run_issues_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == S_RUN) |=> (issue_vld && issue_pc == $past(cur_pc)));

    a_r3_tick_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == S_RUN && tick && !mode_wr && cur_pc != LAST)
        |=> (fsm_state == S_RUN && cur_pc == ADDR_W'($past(cur_pc) + 1'b1)));

    a_r4_sweep_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == S_RUN && cur_pc == LAST && !mode_wr)
        |=> (fsm_state == S_IDLE && cur_pc == '0));

    a_r5_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == S_HALT) |=> !issue_vld);

    a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == S_STEP) |=> (fsm_state == S_HALT && issue_vld));

    a_r9_sat_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_rdata[DBG_SAT_BIT] && !(dbg_wr && dbg_wdata[DBG_SAT_BIT]))
        |=> (dbg_rdata[DBG_SAT_BIT] && $stable(dbg_rdata[DBG_SATA_LSB +: ADDR_W])));

    a_r11_dbac_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !(dbg_wr && dbg_wdata[DBG_ZERO_BIT]))
        |=> (dbac == DBAC_W'($past(dbac) - 1'b1)));

    a_r12_dbac_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_wr && dbg_wdata[DBG_ZERO_BIT]) |=> (dbac == '0));

endmodule

bind dsp_useq dsp_useq_chk #(.ADDR_W(ADDR_W), .DBAC_W(DBAC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .dbg_wr    (dbg_wr),
    .dbg_wdata (dbg_wdata),
    .issue_vld (issue_vld),
    .issue_pc  (issue_pc),
    .dbg_rdata (dbg_rdata),
    .dbac      (dbac),
    .fsm_state (fsm_state),
    .cur_pc    (cur_pc)
);

// File: tb/dsp_useq_bench.sv
`timescale 1ns/1ps
module dsp_useq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [8:0]  ld_addr = '0;
    logic [63:0] ld_data = '0;
    logic        tick = 1'b0;
    logic        dbg_wr = 1'b0;
    logic [31:0] dbg_wdata = '0;
    logic [31:0] dbg_rdata;
    logic        sat_in = 1'b0;
    logic [4:0]  cc_in = '0;
    logic        issue_vld;
    logic [8:0]  issue_pc;
    logic [3:0]  op_code;
    logic [9:0]  op_res, op_a, op_x, op_y;
    logic [19:0] dbac;

    always #5 clk = ~clk;

    dsp_useq u_dsp_useq (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .tick(tick), .dbg_wr(dbg_wr), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
        .sat_in(sat_in), .cc_in(cc_in), .issue_vld(issue_vld), .issue_pc(issue_pc),
        .op_code(op_code), .op_res(op_res), .op_a(op_a), .op_x(op_x), .op_y(op_y),
        .dbac(dbac)
    );

    int total = 0;
    int bad = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [63:0] mmem [512];
    int          m_st;     // 0 idle, 1 run, 2 halt, 3 step
    int          m_pc;
    bit          m_vld;
    int          m_ipc;
    bit          m_sat;
    int          m_sata;
    int          m_cc;
    int          m_dbac;

    always @(posedge clk) begin
        bit nv, clr, mode;
        if (!rst_n) begin
            m_st = 0; m_pc = 0; m_vld = 0; m_ipc = 0;
            m_sat = 0; m_sata = 0; m_cc = 0; m_dbac = 0;
        end else begin
            nv   = (m_st == 1) || (m_st == 3);
            clr  = dbg_wr && dbg_wdata[25];
            mode = dbg_wr && dbg_wdata[15];
            if (m_vld && sat_in && (!m_sat || clr)) begin
                m_sat = 1; m_sata = m_ipc;
            end else if (clr) m_sat = 0;
            if (m_vld) m_cc = cc_in;
            if (dbg_wr && dbg_wdata[31]) m_dbac = 0;
            else if (tick) m_dbac = (m_dbac + 20'hFFFFF) % 32'h100000;
            m_vld = nv;
            if (nv) m_ipc = m_pc;
            case (m_st)
                0: if (mode) begin m_st = dbg_wdata[14] ? 3 : 2; m_pc = dbg_wdata[8:0]; end
                   else if (tick) begin m_st = 1; m_pc = 0; end
                1: if (mode) begin m_st = dbg_wdata[14] ? 3 : 2; m_pc = dbg_wdata[8:0]; end
                   else if (m_pc == 511) begin m_st = 0; m_pc = 0; end
                   else m_pc = m_pc + 1;
                2: if (mode) begin m_st = dbg_wdata[14] ? 3 : 2; m_pc = dbg_wdata[8:0]; end
                   else if (dbg_wr) begin m_st = 0; m_pc = 0; end
                default: begin m_st = 2; m_pc = (m_pc + 1) % 512; end
            endcase
            if (ld_en) mmem[ld_addr] = ld_data;
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        logic [31:0] hi, lo, er;
        logic [43:0] ef, af;
        if (rst_n) begin
            chk(issue_vld == m_vld, "R2 issue_vld", issue_vld, m_vld);
            if (m_vld) begin
                chk(issue_pc == m_ipc[8:0], "R2 issue_pc", issue_pc, m_ipc);
                hi = mmem[m_ipc][63:32];
                lo = mmem[m_ipc][31:0];
                ef = {hi[23:20], hi[19:10], hi[9:0], lo[19:10], lo[9:0]};
                af = {op_code, op_res, op_a, op_x, op_y};
                chk(af == ef, "R1 fields", af, ef);
            end
            er = 32'(m_pc % 512) | (32'(m_cc) << 9) | (32'(m_st >= 2) << 15)
               | (32'(m_sata) << 16) | (32'(m_sat) << 25);
            chk(dbg_rdata == er, "R8 debug view", dbg_rdata, er);
            chk(dbac == m_dbac[19:0], "R11 dbac", dbac, m_dbac);
        end
    end

    // datapath stand-in: feedback tied to the issued instruction
    bit         sat_arm = 0;
    logic [8:0] sat_tgt = '0;
    int         n_iss = 0;
    int         last_pc = 0;

    always @(posedge clk) begin
        #1;
        if (issue_vld) begin n_iss++; last_pc = issue_pc; end
        #2;
        cc_in  = issue_pc[4:0] ^ 5'h15;
        sat_in = sat_arm && issue_vld && (issue_pc == sat_tgt);
    end

    task automatic pulse(input bit t, input bit w, input logic [31:0] d);
        @(posedge clk); #2;
        tick = t; dbg_wr = w; dbg_wdata = d;
        @(posedge clk); #2;
        tick = 0; dbg_wr = 0;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=%0d exp=%0d", 150000, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int c0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk(issue_vld == 0 && dbg_rdata == 0 && dbac == 0, "R13 reset", dbg_rdata, 0);

        for (int i = 0; i < 512; i++) begin
            @(posedge clk); #2;
            ld_en = 1; ld_addr = 9'(i);
            ld_data = {(32'(i) * 32'h9E3779B1) ^ 32'h1234_5678,
                       (32'(i) * 32'h0100_0193) ^ 32'hA5A5_5A5A};
        end
        @(posedge clk); #2 ld_en = 0;
        idle(2);

        // sweep with a second tick mid-way and two saturations
        sat_arm = 1; sat_tgt = 9'd7;
        c0 = n_iss;
        pulse(1, 0, 0);
        chk(dbac == 20'hFFFFF, "R11 wrap", dbac, 20'hFFFFF);
        idle(1);
        chk(issue_vld && issue_pc == 0, "R2 first pc", issue_pc, 0);
        idle(50);
        sat_tgt = 9'd200;
        idle(50);
        pulse(1, 0, 0);
        idle(500);
        chk(n_iss - c0 == 512, "R3 count", n_iss - c0, 512);
        chk(issue_vld == 0, "R4 idle", issue_vld, 0);
        chk(dbg_rdata[25] == 1 && dbg_rdata[24:16] == 7, "R9 first sat", dbg_rdata[24:16], 7);

        pulse(0, 1, 32'h0200_0000);
        chk(dbg_rdata[25] == 0, "R10 clear", dbg_rdata[25], 0);
        sat_tgt = 9'd300;
        pulse(1, 0, 0);
        idle(520);
        chk(dbg_rdata[25] == 1 && dbg_rdata[24:16] == 300, "R9 new sat", dbg_rdata[24:16], 300);
        sat_arm = 0;

        pulse(1, 1, 32'h8000_0000);
        chk(dbac == 0, "R12 zero wins", dbac, 0);

        // single-step mode
        pulse(0, 1, 32'h0000_81FE);
        chk(dbg_rdata[15] == 1 && dbg_rdata[8:0] == 9'h1FE, "R5 halt", dbg_rdata[15:0], 16'h81FE);
        c0 = n_iss;
        pulse(1, 0, 0);
        idle(5);
        chk(n_iss == c0, "R5 no issue", n_iss - c0, 0);
        pulse(0, 1, 32'h0000_C1FE);
        idle(2);
        chk(n_iss == c0 + 1 && last_pc == 510, "R6 step", last_pc, 510);
        chk(dbg_rdata[8:0] == 9'h1FF, "R6 advance", dbg_rdata[8:0], 9'h1FF);
        pulse(0, 1, 32'h0000_C1FF);
        idle(2);
        chk(n_iss == c0 + 2 && last_pc == 511, "R6 step2", last_pc, 511);
        chk(dbg_rdata[8:0] == 0, "R6 wrap", dbg_rdata[8:0], 0);
        chk(dbg_rdata[13:9] == 5'h0A, "R8 cc", dbg_rdata[13:9], 5'h0A);

        pulse(0, 1, 32'h0000_0000);
        chk(dbg_rdata[15] == 0 && dbg_rdata[8:0] == 0, "R7 resume", dbg_rdata[15:0], 0);
        c0 = n_iss;
        pulse(1, 0, 0);
        idle(520);
        chk(n_iss - c0 == 512, "R2 resweep", n_iss - c0, 512);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule